// File: doc/BRIEF.md
# Four-Side Lookup Logic Cell

This block is one tile of a programmable cellular fabric. It has one input and one output on each of its four sides: north, east, south and west. Each output is a purely combinational function of the four side inputs. The functions come from a 64-bit configuration made of four 16-entry truth tables, one table per output side.

The configuration is loaded one bit at a time through a 64-flop scan chain. The chain can be daisy-chained from tile to tile through `scan_in` and `scan_out`. A bank of level-sensitive latches captures the chain contents and drives the lookup logic. While `hold` is asserted, the chain can be rewritten without disturbing the running functions. Releasing `hold` makes the new contents take effect.

Each table is addressed with its inputs ordered relative to its own output side. If all four tables carry the same value, the cell therefore behaves the same in every orientation.

The cell has no sequencer; its only stored states are the chain contents and the captured copy. Three transitions apply:
- Clear: `reset` high at a clock edge loads zeros into the chain.
- Shift: `shift_en` high at a clock edge moves the chain by one position.
- Capture: while `hold` is low, the latch bank is open.

Top module: `lut4_cell`

## Requirements
- R1: Side numbers are north=0, east=1, south=2, west=3. Output side d reads captured configuration bit d*16+idx, where idx is that side's 4-bit index.
- R2: The index for output side d is built as follows: bit 3 is the input of side d, bit 2 is the input of side (d+1) mod 4, bit 1 is the input of side (d+2) mod 4, and bit 0 is the input of side (d+3) mod 4. For the north output this gives north, east, south, west.
- R3: `scan_in` enters chain bit 0, which is north entry 0. Each shift moves chain bit k to bit k+1. `scan_out` is chain bit 63, which is west entry 15. Loading a 64-bit image therefore takes 64 shifts, with bit 63 presented first.
- R4: The chain shifts one position on each rising `clk` edge where `shift_en` is high. When `shift_en` is low, the chain keeps its contents.
- R5: A synchronous `reset` clears every chain bit to zero and takes priority over shifting. It leaves the captured configuration untouched while `hold` is high.
- R6: While `hold` is high, the captured configuration keeps its value, so the outputs ignore any change in the chain.
- R7: While `hold` is low, the captured configuration follows the chain. Reset followed by releasing `hold` drives every output to 0 for every input pattern.
- R8: The outputs respond to the side inputs with no clock edge in the path.
- R9: When all four tables are equal, rotating the input pattern clockwise by one side rotates the outputs clockwise by one side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan chain clock |
| reset | input | 1 | Synchronous chain clear, active high |
| hold | input | 1 | High keeps the captured configuration; low makes it follow the chain |
| shift_en | input | 1 | Chain shift enable |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output (chain bit 63) |
| in_n | input | 1 | North side input |
| in_e | input | 1 | East side input |
| in_s | input | 1 | South side input |
| in_w | input | 1 | West side input |
| out_n | output | 1 | North side output |
| out_e | output | 1 | East side output |
| out_s | output | 1 | South side output |
| out_w | output | 1 | West side output |

## Verification
The bench builds the cell with its default geometry: four sides, 16-entry tables and a 64-bit chain. At this size, every one of the sixteen input patterns can be applied to all four outputs for each loaded image. Several images are loaded serially. Each one is compared in full against a table model computed in the bench, which exposes any misordered index bit, wrong table offset or reversed chain direction. A few short directed sequences cover the remaining behaviour:
- shifting with `hold` high and with the enable low;
- reset with `hold` high;
- rotation of a replicated table.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    localparam int SIDES   = 4;
    localparam int IDX_W   = SIDES;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CFG_W   = SIDES * ENTRIES;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

endpackage

// File: rtl/lutcell_chain.sv
module lutcell_chain #(
    parameter int CFG_W = lutcell_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             reset,
    input  logic             shift_en,
    input  logic             scan_in,
    output logic [CFG_W-1:0] chain_q,
    output logic             scan_out
);

    // Clear has priority; otherwise move one position toward the top bit.
    always_ff @(posedge clk) begin
        if (reset) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[CFG_W-2:0], scan_in};
        end
    end

    assign scan_out = chain_q[CFG_W-1];

    AST_CHAIN_CLEAR: assert property (@(posedge clk)
        reset |=> (chain_q == '0)); // R5

    AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (reset)
        !shift_en |=> $stable(chain_q)); // R4

    AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (reset)
        shift_en |=> (chain_q[0] == $past(scan_in))); // R3

    AST_CHAIN_EXIT: assert property (@(posedge clk) disable iff (reset)
        shift_en |=> (scan_out == $past(chain_q[CFG_W-2]))); // R3

endmodule

// File: rtl/lutcell_capture.sv
module lutcell_capture #(
    parameter int CFG_W = lutcell_pkg::CFG_W
) (
    input  logic             hold,
    input  logic [CFG_W-1:0] chain_d,
    output logic [CFG_W-1:0] cfg_q
);

    // Level-sensitive capture: open while hold is low.
    always_latch begin
        if (!hold) begin
            cfg_q = chain_d;
        end
    end

endmodule

// File: rtl/lutcell_side.sv
module lutcell_side #(
    parameter int SIDES   = lutcell_pkg::SIDES,
    parameter int DIR     = 0,
    parameter int ENTRIES = 1 << SIDES
) (
    input  logic [SIDES-1:0]   side_in,
    input  logic [ENTRIES-1:0] table_bits,
    output logic               out_bit
);

    logic [SIDES-1:0] idx;

    // Index bit (SIDES-1-k) takes the input k steps clockwise from DIR.
    for (genvar k = 0; k < SIDES; k++) begin : g_idx
        assign idx[SIDES-1-k] = side_in[(DIR + k) % SIDES];
    end

    always_comb begin
        out_bit = table_bits[idx];
    end

endmodule

// File: rtl/lut4_cell.sv
module lut4_cell #(
    parameter int SIDES = lutcell_pkg::SIDES
) (
    input  logic clk,
    input  logic reset,
    input  logic hold,
    input  logic shift_en,
    input  logic scan_in,
    output logic scan_out,
    input  logic in_n,
    input  logic in_e,
    input  logic in_s,
    input  logic in_w,
    output logic out_n,
    output logic out_e,
    output logic out_s,
    output logic out_w
);

    localparam int ENTRIES = 1 << SIDES;
    localparam int CFG_W   = SIDES * ENTRIES;

    logic [CFG_W-1:0] chain_q;
    logic [CFG_W-1:0] cfg_q;
    logic [SIDES-1:0] side_in;
    logic [SIDES-1:0] side_out;

    assign side_in[lutcell_pkg::SIDE_N] = in_n;
    assign side_in[lutcell_pkg::SIDE_E] = in_e;
    assign side_in[lutcell_pkg::SIDE_S] = in_s;
    assign side_in[lutcell_pkg::SIDE_W] = in_w;

    lutcell_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .reset    (reset),
        .shift_en (shift_en),
        .scan_in  (scan_in),
        .chain_q  (chain_q),
        .scan_out (scan_out)
    );

    lutcell_capture #(.CFG_W(CFG_W)) u_capture (
        .hold    (hold),
        .chain_d (chain_q),
        .cfg_q   (cfg_q)
    );

    for (genvar d = 0; d < SIDES; d++) begin : g_side
        lutcell_side #(
            .SIDES   (SIDES),
            .DIR     (d),
            .ENTRIES (ENTRIES)
        ) u_side (
            .side_in    (side_in),
            .table_bits (cfg_q[d*ENTRIES +: ENTRIES]),
            .out_bit    (side_out[d])
        );
    end

    assign out_n = side_out[lutcell_pkg::SIDE_N];
    assign out_e = side_out[lutcell_pkg::SIDE_E];
    assign out_s = side_out[lutcell_pkg::SIDE_S];
    assign out_w = side_out[lutcell_pkg::SIDE_W];

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (reset)
        (hold && $past(hold)) |-> $stable(cfg_q)); // R6

    AST_OPEN_FOLLOW: assert property (@(posedge clk) disable iff (reset)
        !hold |-> (cfg_q == chain_q)); // R7

endmodule

// File: tb/lut4_cell_tb.sv
`timescale 1ns/1ps
module lut4_cell_tb;

    logic clk = 1'b0;
    logic reset = 1'b1;
    logic hold = 1'b0;
    logic shift_en = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic in_n = 1'b0, in_e = 1'b0, in_s = 1'b0, in_w = 1'b0;
    logic out_n, out_e, out_s, out_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lut4_cell u_dut (
        .clk(clk), .reset(reset), .hold(hold), .shift_en(shift_en),
        .scan_in(scan_in), .scan_out(scan_out),
        .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
        .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Side k input: north=0, east=1, south=2, west=3.
    task automatic set_ins(input logic [3:0] s);
        in_n = s[0]; in_e = s[1]; in_s = s[2]; in_w = s[3];
    endtask

    function automatic logic [3:0] outs();
        return {out_w, out_s, out_e, out_n};
    endfunction

    function automatic logic model(input logic [63:0] v, input logic [3:0] s, input int d);
        int idx = 0;
        for (int k = 0; k < 4; k++) idx += int'(s[(d + k) % 4]) << (3 - k);
        return v[d*16 + idx];
    endfunction

    task automatic load(input logic [63:0] v);
        for (int i = 63; i >= 0; i--) begin
            @(negedge clk); shift_en = 1'b1; scan_in = v[i];
        end
        @(negedge clk); shift_en = 1'b0; scan_in = 1'b0;
    endtask

    task automatic sweep(input logic [63:0] v, input string req);
        for (int p = 0; p < 16; p++) begin
            set_ins(4'(p));
            #0.5;
            for (int d = 0; d < 4; d++)
                chk(req, outs()[d], model(v, 4'(p), d), $sformatf("pattern %0h side %0d", p, d));
        end
    endtask

    localparam logic [63:0] V1 = 64'hA5C3_0FF0_9669_1E78;
    localparam logic [63:0] V2 = 64'h8000_0001_FFFE_7FFF;
    localparam logic [63:0] V3 = 64'h1357_9BDF_2468_ACE0;

    initial begin
        logic [3:0] o1, o2;
        repeat (4) @(negedge clk);
        reset = 1'b0;
        @(negedge clk);
        // Reset state: chain empty, latches open, all outputs low (R7)
        chk("R7", scan_out, 1'b0, "reset scan_out");
        sweep(64'h0, "R7");

        // Load with hold high: outputs keep old (zero) table (R6)
        hold = 1'b1;
        load(V1);
        set_ins(4'hF); #0.5;
        chk("R6", |outs(), 1'b0, "outputs frozen during load");
        chk("R3", scan_out, V1[63], "scan_out after load");
        @(negedge clk); hold = 1'b0;
        sweep(V1, "R1 R2 R8");

        // Idle with enable low (R4)
        repeat (6) @(negedge clk);
        chk("R4", scan_out, V1[63], "scan_out idle");
        sweep(V1, "R4");

        // Shift out with hold high, observe chain order (R3)
        hold = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); shift_en = 1'b1; scan_in = 1'b0;
            @(negedge clk); shift_en = 1'b0;
            chk("R3", scan_out, V1[62-k], $sformatf("shift-out step %0d", k));
        end
        sweep(V1, "R6");

        load(V2);
        @(negedge clk); hold = 1'b0;
        sweep(V2, "R1 R2");
        hold = 1'b1;
        load(V3);
        @(negedge clk); hold = 1'b0;
        sweep(V3, "R1 R2");

        // Reset with hold high keeps captured table (R5)
        @(negedge clk); hold = 1'b1; shift_en = 1'b1; scan_in = 1'b1; reset = 1'b1;
        @(negedge clk); @(negedge clk); reset = 1'b0; shift_en = 1'b0; scan_in = 1'b0;
        chk("R5", scan_out, 1'b0, "chain cleared");
        sweep(V3, "R5");
        hold = 1'b0;
        sweep(64'h0, "R7");

        // One shifted bit lands at north entry 0 (R3)
        @(negedge clk); shift_en = 1'b1; scan_in = 1'b1;
        @(negedge clk); shift_en = 1'b0; scan_in = 1'b0;
        sweep(64'h1, "R3");

        // Rotation of a replicated table (R9)
        foreach (o1[t]) begin end
        for (int t = 0; t < 2; t++) begin
            logic [15:0] tt = (t == 0) ? 16'h6A3C : 16'hE817;
            hold = 1'b1;
            load({tt, tt, tt, tt});
            @(negedge clk); hold = 1'b0;
            for (int p = 0; p < 16; p++) begin
                logic [3:0] s = 4'(p);
                logic [3:0] r = {s[2:0], s[3]};
                set_ins(s); #0.5; o1 = outs();
                set_ins(r); #0.5; o2 = outs();
                for (int d = 0; d < 4; d++)
                    chk("R9", o2[(d+1)%4], o1[d], $sformatf("table %0d pattern %0h side %0d", t, p, d));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule